// File: doc/BRIEF.md
# Two-Player Dice Round Controller

This block referees one round of a two-player dice game. Each player has a roll button. Pressing it captures the current value of a die counter. The counter runs freely and steps through the faces 1 to 6 on every clock cycle, so the captured face depends on the exact moment of a human press. No fixed sequence is visible to the players.

Each player's latched face goes out on its own three-bit output, ready for a seven-segment decoder. The value zero means "not rolled yet". Once both players have rolled, a registered comparison lights the winner output of the player holding the strictly larger face. On a tie, neither output lights.

A synchronous reset ends the round and starts a new one. The raw buttons are taken to be already debounced but asynchronous to the clock.

Top module: `dice_round`

## Requirements
- R1: While `rst` is high at a rising clock edge, both face outputs become 0 and both win outputs become 0 after that edge.
- R2: The die counter is 1 on the first cycle after reset and advances by one every cycle, wrapping from 6 to 1. A button rising edge is seen three clock edges after the button rises: two synchroniser flops and one edge flop. A roll stores the counter value present just before that third edge, and the stored face is always in the range 1 to 6.
- R3: Neither win output is 1 while either face output is 0.
- R4: Once both faces are non-zero, the win output of the player with the strictly larger face is 1 and the other is 0. This holds from the edge after the second face is stored.
- R5: When both faces are non-zero and equal, both win outputs are 0.
- R6: Once a player's face is non-zero, further presses of that player's button leave that face unchanged until reset.
- R7: A press held for many cycles counts as one roll. A button still held when reset is released makes no roll until it is released and pressed again.
- R8: If both button edges arrive in the same cycle, both faces take the same counter sample, which gives a tie.
- R9: A reset in the middle of a round clears it, and the following round proceeds normally.
- R10: `face_a` always carries player A's roll, and `face_b` always carries player B's roll.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, starts a new round |
| roll_btn_a | input | 1 | Player A roll button, asynchronous, high while pressed |
| roll_btn_b | input | 1 | Player B roll button, asynchronous, high while pressed |
| face_a | output | 3 | Player A face, 0 before the roll, then 1 to 6 |
| face_b | output | 3 | Player B face, 0 before the roll, then 1 to 6 |
| win_a | output | 1 | Player A has the larger face |
| win_b | output | 1 | Player B has the larger face |

## Verification
The assertions assume the buttons are clean level signals: each press is one rise and one fall, with no bounce. They also assume reset is held for at least one edge before a round begins, so the unreset synchroniser flops settle to the idle level first. The stimulus keeps buttons low throughout the opening reset and changes them only on falling clock edges. Held presses, repeated presses, reset while a button is held, and same-cycle presses are all applied as whole-cycle levels, so every expected face can be derived from the cycle count since reset.

// File: rtl/dice_pkg.sv
`timescale 1ns/1ps
package dice_pkg;
  localparam int FACES  = 6;
  localparam int FACE_W = $clog2(FACES + 1);

  typedef logic [FACE_W-1:0] face_t;

  // Next die face: 1..FACES, wrapping back to 1.
  function automatic face_t next_face(input face_t f);
    if (f >= face_t'(FACES) || f == '0) return face_t'(1);
    return f + face_t'(1);
  endfunction

  // Verdict {a_wins, b_wins}; nothing until both have rolled.
  function automatic logic [1:0] judge(input face_t a, input face_t b, input logic both);
    logic [1:0] v;
    v[1] = both && (a > b);
    v[0] = both && (b > a);
    return v;
  endfunction
endpackage

// File: rtl/btn_edge.sv
`timescale 1ns/1ps
module btn_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic btn,
  output logic pulse
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  // Synchroniser data path carries no reset: it is a metastability filter.
  always_ff @(posedge clk) begin
    sync_q <= {sync_q[STAGES-2:0], btn};
    last_q <= sync_q[STAGES-1];
  end

  assign pulse = sync_q[STAGES-1] & ~last_q;

  // A held press yields exactly one pulse.
  p_single_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);
endmodule

// File: rtl/face_counter.sv
`timescale 1ns/1ps
module face_counter
  import dice_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  output face_t cnt
);
  always_ff @(posedge clk) begin
    if (rst) cnt <= face_t'(1);
    else     cnt <= next_face(cnt);
  end

  p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (cnt == face_t'(FACES)) |=> (cnt == face_t'(1)));
  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (cnt != face_t'(FACES)) |=> (cnt == $past(cnt) + face_t'(1)));
endmodule

// File: rtl/roll_slot.sv
`timescale 1ns/1ps
module roll_slot
  import dice_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  take,
  input  face_t sample,
  output face_t face,
  output logic  rolled
);
  always_ff @(posedge clk) begin
    if (rst)                 face <= '0;
    else if (take && !rolled) face <= sample;
  end

  assign rolled = (face != '0);

  p_range_r2: assert property (@(posedge clk) disable iff (rst)
    rolled |-> (face <= face_t'(FACES)));
  p_latch_r2: assert property (@(posedge clk) disable iff (rst)
    (take && !rolled) |=> (face == $past(sample)));
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    rolled |=> $stable(face));
endmodule

// File: rtl/dice_round.sv
`timescale 1ns/1ps
module dice_round
  import dice_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              roll_btn_a,
  input  logic              roll_btn_b,
  output logic [FACE_W-1:0] face_a,
  output logic [FACE_W-1:0] face_b,
  output logic              win_a,
  output logic              win_b
);
  localparam int PLAYERS = 2;

  face_t               die_cnt;
  logic [PLAYERS-1:0]  btn_in;
  logic [PLAYERS-1:0]  press_evt;
  logic [PLAYERS-1:0]  rolled;
  face_t               face_q [PLAYERS];
  logic                both_rolled;
  logic [1:0]          verdict;

  assign btn_in = {roll_btn_b, roll_btn_a};

  face_counter u_cnt (.clk(clk), .rst(rst), .cnt(die_cnt));

  for (genvar p = 0; p < PLAYERS; p++) begin : g_player
    btn_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst(rst), .btn(btn_in[p]), .pulse(press_evt[p]));
    roll_slot u_slot (
      .clk(clk), .rst(rst), .take(press_evt[p]), .sample(die_cnt),
      .face(face_q[p]), .rolled(rolled[p]));
  end

  assign both_rolled = &rolled;
  assign verdict     = judge(face_q[0], face_q[1], both_rolled);

  always_ff @(posedge clk) begin
    if (rst) begin
      win_a <= 1'b0;
      win_b <= 1'b0;
    end else begin
      win_a <= verdict[1];
      win_b <= verdict[0];
    end
  end

  assign face_a = face_q[0];
  assign face_b = face_q[1];

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (face_a == '0 && face_b == '0 && !win_a && !win_b));
  p_no_early_win_r3: assert property (@(posedge clk) disable iff (rst)
    !both_rolled |-> (!win_a && !win_b));
  p_larger_wins_r4: assert property (@(posedge clk) disable iff (rst)
    (both_rolled && face_a > face_b) |=> (win_a && !win_b));
  p_single_winner_r4: assert property (@(posedge clk) disable iff (rst)
    !(win_a && win_b));
  p_tie_dark_r5: assert property (@(posedge clk) disable iff (rst)
    (both_rolled && face_a == face_b) |=> (!win_a && !win_b));
  p_same_sample_r8: assert property (@(posedge clk) disable iff (rst)
    (&press_evt && !rolled[0] && !rolled[1]) |=> (face_a == face_b));
endmodule

// File: tb/sim_dice_round.sv
`timescale 1ns/1ps
module sim_dice_round;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ba  = 1'b0;
  logic       bb  = 1'b0;
  logic [2:0] face_a, face_b;
  logic       win_a, win_b;

  dice_round u0 (
    .clk(clk), .rst(rst), .roll_btn_a(ba), .roll_btn_b(bb),
    .face_a(face_a), .face_b(face_b), .win_a(win_a), .win_b(win_b));

  always #10 clk = ~clk;

  int cyc = 0;
  int die = 1;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) die <= 1;
    else     die <= (die == 6) ? 1 : die + 1;
  end

  typedef struct {
    int    due;
    int    fa;
    int    fb;
    bit    wa;
    bit    wb;
    string tag;
  } item_t;
  item_t sb[$];

  int  exp_a = 0, exp_b = 0;
  bit  exp_wa = 0, exp_wb = 0;
  int  checks = 0, failures = 0;
  bit  done = 0;

  task automatic push(input int due, input string tag);
    item_t it;
    it.due = due; it.fa = exp_a; it.fb = exp_b;
    it.wa = exp_wa; it.wb = exp_wb; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic decide();
    exp_wa = (exp_a != 0) && (exp_b != 0) && (exp_a - exp_b > 0);
    exp_wb = (exp_a != 0) && (exp_b != 0) && (exp_b - exp_a > 0);
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst = 1'b1;
    exp_a = 0; exp_b = 0; exp_wa = 0; exp_wb = 0;
    push(cyc + 1, tag);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic snap(input string tag);
    @(negedge clk);
    push(cyc + 1, tag);
    @(negedge clk);
  endtask

  task automatic roll(input bit pa, input bit pb, input bit let_go, input string tag);
    int n;
    @(negedge clk);
    if (pa) ba = 1'b1;
    if (pb) bb = 1'b1;
    n = cyc;
    @(negedge clk);
    @(negedge clk);
    if (pa && exp_a == 0) exp_a = die;
    if (pb && exp_b == 0) exp_b = die;
    push(n + 3, tag);
    decide();
    push(n + 4, tag);
    if (let_go) begin
      if (pa) ba = 1'b0;
      if (pb) bb = 1'b0;
    end
    repeat (3) @(negedge clk);
  endtask

  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (face_a !== it.fa[2:0] || face_b !== it.fb[2:0] ||
          win_a !== it.wa || win_b !== it.wb) begin
        failures++;
        $display("FAIL %s: got fa=%0d fb=%0d wa=%0b wb=%0b expected fa=%0d fb=%0d wa=%0b wb=%0b",
                 it.tag, face_a, face_b, win_a, win_b, it.fa, it.fb, it.wa, it.wb);
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    do_reset("R1 reset state");
    roll(1, 0, 1, "R2 R3 player A rolls alone");
    roll(0, 1, 1, "R4 R10 player B completes round");
    roll(1, 1, 1, "R6 repeat presses ignored");
    do_reset("R9 mid-game reset");
    roll(1, 1, 1, "R8 R5 simultaneous presses tie");
    for (int i = 0; i < 8; i++) begin
      do_reset("R9 new round");
      repeat (i * 2 + 1) @(negedge clk);
      roll(0, 1, 1, "R2 R3 B first");
      repeat (i) @(negedge clk);
      roll(1, 0, 1, "R4 R5 R10 A second");
    end
    do_reset("R1 before hold test");
    roll(1, 0, 0, "R7 held press rolls once");
    repeat (10) @(negedge clk);
    snap("R7 hold keeps single roll");
    do_reset("R7 reset while held");
    repeat (8) @(negedge clk);
    snap("R7 held across reset no roll");
    ba = 1'b0;
    repeat (4) @(negedge clk);
    roll(1, 0, 1, "R7 fresh press after release");
    do_reset("R9 abort round");
    roll(0, 1, 1, "R9 R3 only B after abort");
    repeat (6) @(negedge clk);
    if (sb.size() != 0) begin
      checks++;
      failures++;
      $display("FAIL scoreboard: %0d items left, expected 0", sb.size());
    end
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule